// File: doc/BRIEF.md
# Downsizing FIFO with bus matching

This block is a two-clock first-in first-out buffer that is written in 36-bit entries and read out in narrower pieces. On the read side each stored entry is split into two 18-bit words or four 9-bit bytes. A size select picks the piece width. An endian select decides whether the most-significant or the least-significant piece of an entry leaves first. Write and read each run on their own clock and reset. The two clocks may be unrelated or may be the same clock. Pointers cross between the domains as Gray code through synchronizer stages.

The status flags follow one of two timing styles, chosen by a mode input. In standard timing the read-side flag means "empty", the write-side flag means "full", and a piece appears on the data output in the cycle after the edge that samples the read enable. In first-word-fall-through timing the read-side flag means "output ready", the write-side flag means "input ready", and the head piece is placed on the output without any read enable. Almost-full and almost-empty flags compare the number of stored entries against offsets. Each offset is either given on input pins or taken from a preset of 8, 16 or 64 entries.

All configuration inputs are static: they are set while both resets are active and held constant afterwards.

Top module: `bm_fifo`

## Requirements
- R1: In word mode (byte_mode=0) each 36-bit entry is delivered as two 18-bit reads on rdata[17:0]. With big_endian=1 the first read is bits 35:18 and the second is bits 17:0. With big_endian=0 the order is reversed.
- R2: In byte mode (byte_mode=1) each entry is delivered as four 9-bit reads on rdata[8:0], and rdata[17:9] reads zero. With big_endian=1 the order is bits 35:27, 26:18, 17:9, 8:0. With big_endian=0 the order is 8:0, 17:9, 26:18, 35:27.
- R3: Entries come out in the order they were written, with no loss and no duplication.
- R4: In standard timing (fwft_mode=0), rflag is the empty flag and wflag is the full flag. A read enable sampled at a rising rclk edge while not empty loads the next piece into rdata right after that edge.
- R5: In first-word-fall-through timing (fwft_mode=1), rflag is output-ready and wflag is input-ready, which is the inverse of full. The head piece appears on rdata with rflag=1 and no read enable. It is held unchanged until a read enable is sampled.
- R6: Occupancy is counted in whole 36-bit entries. An entry stays counted, and keeps empty low, until its last piece has been read. The buffer is full when DEPTH entries are stored.
- R7: A write while full and a read while empty (standard timing) or while not ready (fall-through timing) are ignored, and no pointer moves.
- R8: almost_full is 1 when the number of free entries is at most the effective full offset. almost_empty is 1 when the number of stored entries seen by the read side is at most the effective empty offset.
- R9: ofs_sel picks the effective offsets for both flags: 0 uses the af_ofs and ae_ofs pins, 1 gives 8, 2 gives 16, and 3 gives 64.
- R10: A write and a read on the same clock edge both take effect.
- R11: After a synchronous active-high reset, in standard timing: rflag=1, wflag=0, almost_empty=1, almost_full=0, rdata=0. In fall-through timing: rflag=0 and wflag=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst | input | 1 | Write-domain synchronous reset, active high |
| wen | input | 1 | Write enable |
| wdata | input | 36 | Write data entry |
| wflag | output | 1 | Full (standard) or input-ready (fall-through) |
| almost_full | output | 1 | Free entries at or below the full offset |
| rclk | input | 1 | Read clock |
| rrst | input | 1 | Read-domain synchronous reset, active high |
| ren | input | 1 | Read enable |
| rdata | output | 18 | Read piece, registered |
| rflag | output | 1 | Empty (standard) or output-ready (fall-through) |
| almost_empty | output | 1 | Stored entries at or below the empty offset |
| fwft_mode | input | 1 | 1 selects first-word-fall-through timing |
| byte_mode | input | 1 | 1 selects 9-bit reads, 0 selects 18-bit reads |
| big_endian | input | 1 | 1 sends the most-significant piece first |
| ofs_sel | input | 2 | Offset source: pins, 8, 16 or 64 |
| af_ofs | input | AW+1 | Full offset used when ofs_sel=0 |
| ae_ofs | input | AW+1 | Empty offset used when ofs_sel=0 |

## Verification
Six stored words are read back through every combination of piece width and endian order. The words are built from distinct 9-bit bytes, so a swapped half, a swapped byte, an unzeroed upper byte lane or a reversed order each produces a different value. A run that fills all 256 entries with index-coded words, tries one more write, and then drains the buffer tells apart lost, repeated and extra entries. The same run places the full and almost-full edges on exact entry counts. Further directed sequences separate the two flag timings by whether data shows up without a read enable, confirm that the preset and pin offsets move the almost-empty edge to the right count, and interleave a same-edge read and write, which must keep both words.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

  typedef enum logic [1:0] {
    OFS_PINS = 2'd0,
    OFS_8    = 2'd1,
    OFS_16   = 2'd2,
    OFS_64   = 2'd3
  } ofs_sel_e;

  // Preset offset chosen by the select code; zero for the pin-driven case.
  function automatic int unsigned preset_ofs(input logic [1:0] sel);
    case (ofs_sel_e'(sel))
      OFS_8:   return 8;
      OFS_16:  return 16;
      OFS_64:  return 64;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/bmf_ptr_sync.sv
module bmf_ptr_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= gray_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  function automatic logic [W-1:0] gray2bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign bin_out = gray2bin(stg[STAGES-1]);

endmodule

// File: rtl/bmf_ram.sv
module bmf_ram #(
  parameter int DW    = 36,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    q <= mem[raddr];
  end

endmodule

// File: rtl/bmf_wr_side.sv
module bmf_wr_side #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wen,
  input  logic [CW-1:0] rbin_sync,
  input  logic [CW-1:0] af_eff,
  output logic          wr_ok,
  output logic [CW-1:0] wbin,
  output logic [CW-1:0] wgray,
  output logic [CW-1:0] wfill,
  output logic          full,
  output logic          almost_full
);

  logic [CW-1:0] wbin_nx;

  assign wfill       = wbin - rbin_sync;
  assign full        = (wfill == CW'(DEPTH));
  assign almost_full = ((CW'(DEPTH) - wfill) <= af_eff);
  assign wr_ok       = wen && !full;
  assign wbin_nx     = wbin + CW'(wr_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

endmodule

// File: rtl/bmf_rd_side.sv
module bmf_rd_side #(
  parameter int DEPTH = 512,
  parameter int DW    = 36,
  parameter int RW    = 18,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int BW   = RW / 2,
  localparam int NW   = DW / RW,
  localparam int NB   = DW / BW,
  localparam int SW   = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren,
  input  logic          fwft,
  input  logic          byte_mode,
  input  logic          big_end,
  input  logic [CW-1:0] wbin_sync,
  input  logic [CW-1:0] ae_eff,
  input  logic [DW-1:0] ram_q,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] rbin,
  output logic [CW-1:0] rgray,
  output logic [CW-1:0] rfill,
  output logic          avail,
  output logic          ovalid,
  output logic          almost_empty,
  output logic [RW-1:0] rdata
);

  logic [SW-1:0] scnt;
  logic [SW-1:0] last_idx;
  logic [SW-1:0] pos;
  logic          last;
  logic          load;
  logic [CW-1:0] rbin_nx;
  logic [RW-1:0] piece;

  assign rfill        = wbin_sync - rbin;
  assign avail        = (rfill != '0);
  assign almost_empty = (rfill <= ae_eff);

  assign last_idx = byte_mode ? SW'(NB - 1) : SW'(NW - 1);
  assign last     = (scnt == last_idx);
  assign pos      = big_end ? (last_idx - scnt) : scnt;

  always_comb begin
    if (fwft) load = (!ovalid || ren) && avail;
    else      load = ren && avail;
  end

  always_comb begin
    if (byte_mode) piece = {{(RW - BW){1'b0}}, ram_q[pos*BW +: BW]};
    else           piece = ram_q[pos*RW +: RW];
  end

  // Entry is released only when its last piece leaves the array.
  assign rbin_nx = rbin + CW'(load && last);
  assign raddr   = rbin_nx[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin   <= '0;
      rgray  <= '0;
      scnt   <= '0;
      rdata  <= '0;
      ovalid <= 1'b0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      if (load) begin
        rdata <= piece;
        scnt  <= last ? '0 : scnt + 1'b1;
      end
      if (!fwft)                ovalid <= 1'b0;
      else if (!ovalid || ren)  ovalid <= avail;
    end
  end

endmodule

// File: rtl/bm_fifo.sv
module bm_fifo #(
  parameter int DEPTH = 512,
  parameter int DW    = 36,
  parameter int RW    = 18,
  parameter int SYNC  = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          wflag,
  output logic          almost_full,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          ren,
  output logic [RW-1:0] rdata,
  output logic          rflag,
  output logic          almost_empty,
  input  logic          fwft_mode,
  input  logic          byte_mode,
  input  logic          big_endian,
  input  logic [1:0]    ofs_sel,
  input  logic [CW-1:0] af_ofs,
  input  logic [CW-1:0] ae_ofs
);

  import bmf_pkg::*;

  logic [CW-1:0] wbin, wgray, wfill, rbin_sync;
  logic [CW-1:0] rbin, rgray, rfill, wbin_sync;
  logic [CW-1:0] af_eff, ae_eff;
  logic [AW-1:0] raddr;
  logic [DW-1:0] ram_q;
  logic          wr_ok, full_w, avail, ovalid;

  assign af_eff = (ofs_sel == OFS_PINS) ? af_ofs : CW'(preset_ofs(ofs_sel));
  assign ae_eff = (ofs_sel == OFS_PINS) ? ae_ofs : CW'(preset_ofs(ofs_sel));

  bmf_wr_side #(.DEPTH(DEPTH)) u_wr (
    .clk(wclk), .rst(wrst), .wen(wen), .rbin_sync(rbin_sync), .af_eff(af_eff),
    .wr_ok(wr_ok), .wbin(wbin), .wgray(wgray), .wfill(wfill),
    .full(full_w), .almost_full(almost_full)
  );

  bmf_ptr_sync #(.W(CW), .STAGES(SYNC)) u_r2w (
    .clk(wclk), .rst(wrst), .gray_in(rgray), .bin_out(rbin_sync)
  );

  bmf_ptr_sync #(.W(CW), .STAGES(SYNC)) u_w2r (
    .clk(rclk), .rst(rrst), .gray_in(wgray), .bin_out(wbin_sync)
  );

  bmf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .wclk(wclk), .we(wr_ok), .waddr(wbin[AW-1:0]), .wdata(wdata),
    .rclk(rclk), .raddr(raddr), .q(ram_q)
  );

  bmf_rd_side #(.DEPTH(DEPTH), .DW(DW), .RW(RW)) u_rd (
    .clk(rclk), .rst(rrst), .ren(ren), .fwft(fwft_mode), .byte_mode(byte_mode),
    .big_end(big_endian), .wbin_sync(wbin_sync), .ae_eff(ae_eff), .ram_q(ram_q),
    .raddr(raddr), .rbin(rbin), .rgray(rgray), .rfill(rfill), .avail(avail),
    .ovalid(ovalid), .almost_empty(almost_empty), .rdata(rdata)
  );

  assign wflag = fwft_mode ? !full_w : full_w;
  assign rflag = fwft_mode ? ovalid  : !avail;

endmodule

// File: rtl/bmf_chk.sv
module bmf_chk #(
  parameter int DEPTH = 512,
  parameter int RW    = 18,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input logic          wclk,
  input logic          wrst,
  input logic          rclk,
  input logic          rrst,
  input logic          wen,
  input logic          ren,
  input logic          fwft,
  input logic          full_i,
  input logic          almost_full,
  input logic [CW-1:0] wbin,
  input logic [CW-1:0] wfill,
  input logic [CW-1:0] rbin,
  input logic [CW-1:0] rfill,
  input logic          ovalid,
  input logic [RW-1:0] rdata
);

  // R7: a blocked write leaves the write pointer alone
  p_full_blocks_write_r7: assert property (@(posedge wclk) disable iff (wrst)
    (full_i && wen) |=> (wbin == $past(wbin)));

  // R7: nothing stored on the read side means the read pointer holds
  p_empty_blocks_read_r7: assert property (@(posedge rclk) disable iff (rrst)
    (rfill == '0) |=> (rbin == $past(rbin)));

  // R6: write-side occupancy never exceeds the depth
  p_no_overflow_r6: assert property (@(posedge wclk) disable iff (wrst)
    wfill <= CW'(DEPTH));

  // R6: read-side occupancy never exceeds the depth
  p_no_underflow_r6: assert property (@(posedge rclk) disable iff (rrst)
    rfill <= CW'(DEPTH));

  // R5: presented piece is held until a read is taken
  p_fwft_hold_r5: assert property (@(posedge rclk) disable iff (rrst)
    (fwft && ovalid && !ren) |=> (ovalid && $stable(rdata)));

  // R8: a full buffer always reports almost full
  p_full_is_af_r8: assert property (@(posedge wclk) disable iff (wrst)
    full_i |-> almost_full);

endmodule

bind bm_fifo bmf_chk #(.DEPTH(DEPTH), .RW(RW)) u_chk (
  .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst), .wen(wen), .ren(ren),
  .fwft(fwft_mode), .full_i(full_w), .almost_full(almost_full), .wbin(wbin),
  .wfill(wfill), .rbin(rbin), .rfill(rfill), .ovalid(ovalid), .rdata(rdata)
);

// File: tb/sim_bm_fifo.sv
module sim_bm_fifo;

  localparam int DEPTH = 256;
  localparam int CW    = $clog2(DEPTH) + 1;

  typedef struct packed {
    logic             bmode;
    logic             big;
    logic [35:0]      w;
    logic [3:0][17:0] e;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 1'b1, {9'h1A5, 9'h0C3, 9'h13C, 9'h07E},
      {18'h0, 18'h0, {9'h13C, 9'h07E}, {9'h1A5, 9'h0C3}}},
    '{1'b0, 1'b0, {9'h1A5, 9'h0C3, 9'h13C, 9'h07E},
      {18'h0, 18'h0, {9'h1A5, 9'h0C3}, {9'h13C, 9'h07E}}},
    '{1'b1, 1'b1, {9'h1A5, 9'h0C3, 9'h13C, 9'h07E},
      {{9'h0, 9'h07E}, {9'h0, 9'h13C}, {9'h0, 9'h0C3}, {9'h0, 9'h1A5}}},
    '{1'b1, 1'b0, {9'h1A5, 9'h0C3, 9'h13C, 9'h07E},
      {{9'h0, 9'h1A5}, {9'h0, 9'h0C3}, {9'h0, 9'h13C}, {9'h0, 9'h07E}}},
    '{1'b0, 1'b1, {9'h0FF, 9'h100, 9'h001, 9'h1FE},
      {18'h0, 18'h0, {9'h001, 9'h1FE}, {9'h0FF, 9'h100}}},
    '{1'b1, 1'b0, {9'h0FF, 9'h100, 9'h001, 9'h1FE},
      {{9'h0, 9'h0FF}, {9'h0, 9'h100}, {9'h0, 9'h001}, {9'h0, 9'h1FE}}}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wen = 1'b0, ren = 1'b0;
  logic [35:0]   wdata = '0;
  logic          fwft = 1'b0, bmode = 1'b0, big = 1'b1;
  logic [1:0]    osel = 2'd0;
  logic [CW-1:0] afo = '0, aeo = '0;
  logic          wflag, rflag, af, ae;
  logic [17:0]   rdata;
  int            n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  bm_fifo #(.DEPTH(DEPTH)) u0 (
    .wclk(clk), .wrst(rst), .wen(wen), .wdata(wdata), .wflag(wflag),
    .almost_full(af), .rclk(clk), .rrst(rst), .ren(ren), .rdata(rdata),
    .rflag(rflag), .almost_empty(ae), .fwft_mode(fwft), .byte_mode(bmode),
    .big_endian(big), .ofs_sel(osel), .af_ofs(afo), .ae_ofs(aeo)
  );

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic f, input logic b, input logic e,
                          input logic [1:0] s, input int a_f, input int a_e);
    @(negedge clk);
    rst = 1'b1; wen = 1'b0; ren = 1'b0;
    fwft = f; bmode = b; big = e; osel = s;
    afo = CW'(a_f); aeo = CW'(a_e);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [35:0] d);
    wen = 1'b1; wdata = d;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd();
    ren = 1'b1;
    @(negedge clk);
    ren = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [35:0] fill_word(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b, ~b, 4'h5, b, ~b};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R11: reset state, standard timing
    do_reset(1'b0, 1'b0, 1'b1, 2'd0, 4, 3);
    idle(1);
    chk("R11 empty after reset", 36'(rflag), 36'd1);
    chk("R11 full after reset", 36'(wflag), 36'd0);
    chk("R11 almost_empty after reset", 36'(ae), 36'd1);
    chk("R11 almost_full after reset", 36'(af), 36'd0);
    chk("R11 rdata after reset", 36'(rdata), 36'd0);

    // R1 R2 R3: vector table over piece width and endian order
    for (int v = 0; v < 6; v++) begin
      int n;
      do_reset(1'b0, VEC[v].bmode, VEC[v].big, 2'd0, 4, 3);
      n = VEC[v].bmode ? 4 : 2;
      wr(VEC[v].w);
      idle(4);
      for (int k = 0; k < n; k++) begin
        if (k == n - 1) chk($sformatf("R6 entry held before last piece v%0d", v), 36'(rflag), 36'd0);
        rd();
        chk($sformatf("R1/R2 piece v%0d k%0d", v, k), 36'(rdata), 36'(VEC[v].e[k]));
      end
      chk($sformatf("R4 empty after entry v%0d", v), 36'(rflag), 36'd1);
    end

    // R7: read while empty is ignored and pointer does not move
    do_reset(1'b0, 1'b0, 1'b1, 2'd0, 4, 3);
    idle(1);
    rd(); rd(); rd();
    chk("R7 rdata after empty reads", 36'(rdata), 36'd0);
    chk("R7 still empty", 36'(rflag), 36'd1);
    wr(36'h2_4680_1357);
    idle(4);
    rd();
    chk("R7 first piece after empty reads", 36'(rdata), 36'(36'h2_4680_1357 >> 18));

    // R6 R7 R8: fill to full, overfill, drain
    do_reset(1'b0, 1'b0, 1'b1, 2'd0, 4, 3);
    for (int i = 1; i <= DEPTH; i++) begin
      wr(fill_word(i - 1));
      if (i == 251) chk("R8 almost_full at 5 free", 36'(af), 36'd0);
      if (i == 252) chk("R8 almost_full at 4 free", 36'(af), 36'd1);
      if (i == 255) chk("R6 not full at 255", 36'(wflag), 36'd0);
      if (i == 256) chk("R6 full at 256", 36'(wflag), 36'd1);
    end
    wr(36'hF_FFFF_FFFF);
    chk("R7 full holds after extra write", 36'(wflag), 36'd1);
    idle(4);
    chk("R8 almost_empty off when full", 36'(ae), 36'd0);
    for (int i = 0; i < DEPTH; i++) begin
      logic [35:0] w;
      w = fill_word(i);
      rd();
      chk($sformatf("R3 high half entry %0d", i), 36'(rdata), 36'(w[35:18]));
      rd();
      chk($sformatf("R3 low half entry %0d", i), 36'(rdata), 36'(w[17:0]));
    end
    chk("R7 extra write not stored", 36'(rflag), 36'd1);
    idle(4);
    chk("R6 full cleared after drain", 36'(wflag), 36'd0);

    // R9 R8: almost_empty edge for each offset source
    for (int s = 0; s < 4; s++) begin
      int t;
      t = (s == 0) ? 3 : (s == 1) ? 8 : (s == 2) ? 16 : 64;
      do_reset(1'b0, 1'b0, 1'b1, 2'(s), 4, 3);
      for (int i = 0; i < t; i++) wr(fill_word(i));
      idle(4);
      chk($sformatf("R9 almost_empty at %0d entries", t), 36'(ae), 36'd1);
      wr(fill_word(t));
      idle(4);
      chk($sformatf("R9 almost_empty at %0d entries", t + 1), 36'(ae), 36'd0);
    end

    // R9: preset 64 on almost_full
    do_reset(1'b0, 1'b0, 1'b1, 2'd3, 4, 3);
    for (int i = 1; i <= 192; i++) begin
      wr(fill_word(i));
      if (i == 191) chk("R9 almost_full 65 free", 36'(af), 36'd0);
      if (i == 192) chk("R9 almost_full 64 free", 36'(af), 36'd1);
    end

    // R10: same-edge write and read
    do_reset(1'b0, 1'b0, 1'b1, 2'd0, 4, 3);
    wr(36'h1_1111_2222);
    wr(36'h3_3333_4444);
    idle(4);
    rd();
    chk("R10 A high", 36'(rdata), 36'(36'h1_1111_2222 >> 18));
    wen = 1'b1; wdata = 36'h5_5555_6666; ren = 1'b1;
    @(negedge clk);
    wen = 1'b0; ren = 1'b0;
    chk("R10 A low on shared edge", 36'(rdata), 36'(18'(36'h1_1111_2222)));
    idle(4);
    rd(); chk("R10 B high", 36'(rdata), 36'(36'h3_3333_4444 >> 18));
    rd(); chk("R10 B low", 36'(rdata), 36'(18'(36'h3_3333_4444)));
    rd(); chk("R10 C high", 36'(rdata), 36'(36'h5_5555_6666 >> 18));
    rd(); chk("R10 C low", 36'(rdata), 36'(18'(36'h5_5555_6666)));
    chk("R10 empty after both", 36'(rflag), 36'd1);

    // R5 R11: fall-through timing
    do_reset(1'b1, 1'b0, 1'b1, 2'd0, 4, 3);
    idle(1);
    chk("R11 output-ready after reset", 36'(rflag), 36'd0);
    chk("R11 input-ready after reset", 36'(wflag), 36'd1);
    wr(36'h7_89AB_CDEF);
    idle(5);
    chk("R5 ready without read enable", 36'(rflag), 36'd1);
    chk("R5 head piece shown", 36'(rdata), 36'(36'h7_89AB_CDEF >> 18));
    idle(3);
    chk("R5 head piece held", 36'(rdata), 36'(36'h7_89AB_CDEF >> 18));
    rd();
    chk("R5 second piece", 36'(rdata), 36'(18'(36'h7_89AB_CDEF)));
    chk("R5 still ready on last piece", 36'(rflag), 36'd1);
    rd();
    chk("R5 not ready after drain", 36'(rflag), 36'd0);
    rd();
    chk("R7 read while not ready ignored", 36'(rflag), 36'd0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule